// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a synchronous static RAM with a pipelined read path and single-cycle deselect. It stores 36-bit words. Each word is split into four 9-bit byte lanes, and the top bit of each lane is that lane's parity bit. All address, enable and write-control inputs are sampled on the rising clock edge. The sampled access is held in an access register, and the array is written one edge later. A write therefore needs no further timing from the outside.

A burst starts when either of two address strobes is asserted while the device is selected. Selection needs all three chip enables, which have mixed polarity. The first access uses the external address. Later accesses take their address from an internal 2-bit burst counter, which moves on only while the burst-advance input is low. A mode input picks the burst order: linear or interleaved. Read data goes through a registered output stage. The pad driver enable is registered in the same stage and gated without a clock by the output enable. When the device is deselected right after a read, the read's data is still presented, and the output floats one edge later.

Top module: `sbsram_top`

## Requirements
- R1: A strobe cycle starts a burst only when `en_n`=0, `en2`=1 and `en3_n`=0. A strobe cycle that fails this deselects the device, and the output floats two edges later. A `astb_cpu_n` strobe taken while `en_n`=1 is ignored: the cycle is treated as a no-strobe cycle.
- R2: A strobe on either `astb_cpu_n` or `astb_ctl_n` (active low) that meets R1 captures `addr_i` at that edge as the burst's first access address.
- R3: In a cycle with no strobe during an active burst, the access address advances only when `burst_step_n`=0. Otherwise the same address is accessed again.
- R4: With `burst_lin`=1 (linear order), access k of a burst uses low address bits (start+k) mod 4. The upper address bits stay fixed, so a burst from offset 1 visits 1,2,3,0.
- R5: With `burst_lin`=0 (interleaved order), access k uses low address bits start XOR k. A burst from offset 1 visits 1,0,3,2.
- R6: Lane i covers data bits [9i+8:9i], with bit 9i+8 as its parity bit. The lane is written when `lane_we_n[i]`=0 in an access cycle. Lanes whose enable is high keep their stored contents.
- R7: `all_we_n`=0 writes all four lanes whatever `lane_we_n` holds.
- R8: A read access sampled at edge E puts the stored word on `q_o` and raises `q_drive_o` after edge E+2.
- R9: A deselect sampled at edge E+1, right after a read at edge E, leaves the read data driven after edge E+2. The output then floats after edge E+3, and `q_o` keeps its value.
- R10: `oe_n`=1 forces `q_drive_o` low without waiting for a clock edge. Returning it to 0 restores the registered drive state.
- R11: After reset, `q_o`=0 and `q_drive_o`=0. A write access sampled at edge E leaves `q_drive_o`=0 after edge E+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control and output state |
| en_n | input | 1 | Primary chip enable, active low |
| en2 | input | 1 | Second chip enable, active high |
| en3_n | input | 1 | Third chip enable, active low |
| astb_cpu_n | input | 1 | Address strobe, processor side, active low; ignored while en_n is high |
| astb_ctl_n | input | 1 | Address strobe, controller side, active low |
| burst_step_n | input | 1 | Burst advance, active low |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr_i | input | ADDR_W | Word address |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| all_we_n | input | 1 | Write all lanes, active low |
| oe_n | input | 1 | Output enable, active low, unclocked |
| d_i | input | LANES*LANE_W | Write data |
| q_o | output | LANES*LANE_W | Registered read data |
| q_drive_o | output | 1 | Pad driver enable; 0 means high impedance |

## Verification
If the burst counter, the base address or the burst order were wrong, the wrong stored word would appear on `q_o` exactly two edges after the access that used it. Each step of a burst therefore shows up as a data mismatch in its own cycle. If the lane mask were wrong, the next read of that word would have a corrupted or stale 9-bit field. If the drive pipeline lost its alignment, `q_drive_o` would float one edge early or one edge late around a deselect or a write. A selection decode that ignored one of the enables would either leave the output driven where it should float, or leave the old burst running where a strobe should have ended it.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  // Offset of the low two address bits for burst step `step`.
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] step,
                                              input logic       lin);
    logic [1:0] r;
    if (lin) r = start + step;
    else     r = start ^ step;
    return r;
  endfunction

endpackage

// File: rtl/sbsram_seq.sv
module sbsram_seq
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic              astb_cpu_n,
  input  logic              astb_ctl_n,
  input  logic              burst_step_n,
  input  logic              burst_lin,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              all_we_n,
  input  logic [WORD_W-1:0] d_i,
  output acc_kind_e         acc_kind,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  acc_mask,
  output logic [WORD_W-1:0] acc_wdata
);

  logic              active;
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;

  // Named events for the assertions.
  logic cpu_start, ctl_start, start_req, selected;
  logic new_burst, drop, advance, suspend;
  logic [1:0]        cnt_nxt;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  wr_mask;
  logic              access;

  always_comb begin
    cpu_start = !astb_cpu_n && !en_n;
    ctl_start = !astb_ctl_n;
    start_req = cpu_start || ctl_start;
    selected  = !en_n && en2 && !en3_n;
    new_burst = start_req && selected;
    drop      = start_req && !selected;
    advance   = !start_req && active && !burst_step_n;
    suspend   = !start_req && active && burst_step_n;
    access    = new_burst || advance || suspend;
    cnt_nxt   = advance ? cnt + 2'd1 : cnt;
    if (new_burst)
      cur_addr = addr_i;
    else
      cur_addr = {base[ADDR_W-1:2], burst_offset(base[1:0], cnt_nxt, burst_lin)};
    wr_mask = all_we_n ? ~lane_we_n : {LANES{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      base      <= '0;
      cnt       <= 2'd0;
      acc_kind  <= ACC_NONE;
      acc_addr  <= '0;
      acc_mask  <= '0;
      acc_wdata <= '0;
    end else begin
      if (new_burst) begin
        active <= 1'b1;
        base   <= addr_i;
        cnt    <= 2'd0;
      end else if (drop) begin
        active <= 1'b0;
      end else if (advance) begin
        cnt <= cnt_nxt;
      end
      if (access) begin
        acc_kind  <= (|wr_mask) ? ACC_WRITE : ACC_READ;
        acc_addr  <= cur_addr;
        acc_mask  <= wr_mask;
        acc_wdata <= d_i;
      end else begin
        acc_kind <= ACC_NONE;
      end
    end
  end

  // R1: an unselected strobe leaves no access behind it.
  a_r1_drop_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (acc_kind == ACC_NONE));

  // R2: a selected strobe accesses the external address.
  a_r2_start_capture: assert property (@(posedge clk) disable iff (!rst_n)
    new_burst |=> (acc_addr == $past(addr_i)));

  // R3: without advance the address repeats.
  a_r3_hold_address: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> $stable(acc_addr));

  // R4: linear order steps the low bits by one, wrapping.
  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && burst_lin) |=>
      (acc_addr[1:0] == 2'($past(acc_addr[1:0]) + 2'd1)));

endmodule

// File: rtl/sbsram_lane_mem.sv
module sbsram_lane_mem #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata <= mem[addr];
  end

endmodule

// File: rtl/sbsram_outpipe.sv
module sbsram_outpipe #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              oe_n,
  output logic [WORD_W-1:0] q_o,
  output logic              q_drive_o,
  output logic              drive_state
);

  logic              rd_flag;
  logic [WORD_W-1:0] q_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_flag     <= 1'b0;
      q_reg       <= '0;
      drive_state <= 1'b0;
    end else begin
      rd_flag     <= rd_issue;
      drive_state <= rd_flag;
      if (rd_flag) q_reg <= rd_word;
    end
  end

  assign q_o       = q_reg;
  assign q_drive_o = drive_state && !oe_n;

endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic              astb_cpu_n,
  input  logic              astb_ctl_n,
  input  logic              burst_step_n,
  input  logic              burst_lin,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              all_we_n,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] d_i,
  output logic [WORD_W-1:0] q_o,
  output logic              q_drive_o
);

  acc_kind_e         acc_kind;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_mask;
  logic [WORD_W-1:0] acc_wdata;
  logic [WORD_W-1:0] rd_word;
  logic              rd_issue;
  logic              drive_state;

  sbsram_seq #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) seq_i (
    .clk, .rst_n, .en_n, .en2, .en3_n, .astb_cpu_n, .astb_ctl_n,
    .burst_step_n, .burst_lin, .addr_i, .lane_we_n, .all_we_n, .d_i,
    .acc_kind, .acc_addr, .acc_mask, .acc_wdata
  );

  assign rd_issue = (acc_kind == ACC_READ);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_wr;
    assign lane_wr = (acc_kind == ACC_WRITE) && acc_mask[g];
    sbsram_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) mem_i (
      .clk   (clk),
      .wr_en (lane_wr),
      .rd_en (rd_issue),
      .addr  (acc_addr),
      .wdata (acc_wdata[g*LANE_W +: LANE_W]),
      .rdata (rd_word[g*LANE_W +: LANE_W])
    );
  end

  sbsram_outpipe #(.WORD_W(WORD_W)) out_i (
    .clk, .rst_n, .rd_issue, .rd_word, .oe_n, .q_o, .q_drive_o, .drive_state
  );

  // R8: a read access is driven two edges later.
  a_r8_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_READ) |=> ##1 drive_state);

  // R11: a write access never drives the output.
  a_r11_write_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_WRITE) |=> ##1 !drive_state);

  // R9: once deselected, the output floats after the pipeline drains.
  a_r9_idle_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_NONE) |=> ##1 !drive_state);

endmodule

// File: tb/sbsram_top_tb.sv
module sbsram_top_tb_top;

  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int NVEC   = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic en_n, en2, en3_n, astb_cpu_n, astb_ctl_n, burst_step_n, burst_lin;
  logic [ADDR_W-1:0] addr_i;
  logic [LANES-1:0]  lane_we_n;
  logic              all_we_n, oe_n;
  logic [WORD_W-1:0] d_i, q_o;
  logic              q_drive_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [WORD_W-1:0] mdl [1 << ADDR_W];

  // Vector fields: {addr(6), all_we_n(1), lane_we_n(4), data(36)}
  localparam logic [46:0] VEC [NVEC] = '{
    {6'd3,  1'b0, 4'hF,    36'h1_2345_6789},
    {6'd17, 1'b0, 4'h0,    36'hA_BCDE_F012},
    {6'd16, 1'b0, 4'h5,    36'h3_1415_9265},
    {6'd18, 1'b0, 4'hF,    36'h2_7182_8182},
    {6'd19, 1'b0, 4'hA,    36'hF_0F0F_0F0F},
    {6'd3,  1'b1, 4'b1110, 36'h0_0000_01FF},
    {6'd17, 1'b1, 4'b0101, 36'h5_5555_5555},
    {6'd63, 1'b1, 4'b0111, 36'hC_0000_0000}
  };

  sbsram_top #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk, .rst_n, .en_n, .en2, .en3_n, .astb_cpu_n, .astb_ctl_n,
    .burst_step_n, .burst_lin, .addr_i, .lane_we_n, .all_we_n, .oe_n,
    .d_i, .q_o, .q_drive_o
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [WORD_W-1:0] act,
                     input logic [WORD_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    en_n = 1'b0; en2 = 1'b1; en3_n = 1'b0;
    astb_cpu_n = 1'b1; astb_ctl_n = 1'b1; burst_step_n = 1'b1;
    lane_we_n = '1; all_we_n = 1'b1;
  endtask

  task automatic write_word(input logic [ADDR_W-1:0] a, input logic gw_n,
                            input logic [LANES-1:0] we_n,
                            input logic [WORD_W-1:0] dat);
    idle();
    astb_ctl_n = 1'b0; addr_i = a; all_we_n = gw_n; lane_we_n = we_n; d_i = dat;
    tick();
    idle();
    for (int l = 0; l < LANES; l++)
      if (!gw_n || !we_n[l])
        mdl[a][l*LANE_W +: LANE_W] = dat[l*LANE_W +: LANE_W];
  endtask

  task automatic start_read(input logic [ADDR_W-1:0] a, input logic use_cpu);
    idle();
    if (use_cpu) astb_cpu_n = 1'b0; else astb_ctl_n = 1'b0;
    addr_i = a;
    tick();
    idle();
  endtask

  // Burst from offset 1 of block 16..19; expected order given by caller.
  task automatic burst_check(input logic lin, input logic [ADDR_W-1:0] o0,
                             input logic [ADDR_W-1:0] o1,
                             input logic [ADDR_W-1:0] o2,
                             input logic [ADDR_W-1:0] o3, input string tag);
    burst_lin = lin;
    start_read(6'd17, 1'b1);
    burst_step_n = 1'b0; tick();
    burst_step_n = 1'b0; tick();
    chk({tag, " step0"}, q_o, mdl[o0]);
    burst_step_n = 1'b0; tick();
    chk({tag, " step1"}, q_o, mdl[o1]);
    burst_step_n = 1'b1; tick();
    chk({tag, " step2"}, q_o, mdl[o2]);
    tick();
    chk({tag, " step3"}, q_o, mdl[o3]);
    burst_lin = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; idle(); burst_lin = 1'b1; oe_n = 1'b0;
    addr_i = '0; d_i = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R11: reset state
    chk("R11 reset q", q_o, '0);
    chk("R11 reset drive", {35'd0, q_drive_o}, 36'd1 - 36'd1);

    // Table walk: R6/R7 lane writes, R2 controller-strobe capture, R8 latency
    for (int v = 0; v < NVEC; v++) begin
      write_word(VEC[v][46:41], VEC[v][40], VEC[v][39:36], VEC[v][35:0]);
      start_read(VEC[v][46:41], v[0]);
      tick(); tick();
      chk($sformatf("R6 R7 R8 vec%0d data", v), q_o, mdl[VEC[v][46:41]]);
      chk($sformatf("R8 R2 vec%0d drive", v), {35'd0, q_drive_o}, 36'd1);
    end

    // R4 linear, R5 interleaved burst orders from offset 1
    burst_check(1'b1, 6'd17, 6'd18, 6'd19, 6'd16, "R4 linear");
    burst_check(1'b0, 6'd17, 6'd16, 6'd19, 6'd18, "R5 interleaved");

    // R3: no advance keeps re-reading the start address
    start_read(6'd18, 1'b1);
    tick(); tick();
    chk("R3 hold a", q_o, mdl[18]);
    tick();
    chk("R3 hold b", q_o, mdl[18]);

    // R10: unclocked output-enable gating
    oe_n = 1'b1; #1;
    chk("R10 oe high floats", {35'd0, q_drive_o}, 36'd0);
    oe_n = 1'b0; #1;
    chk("R10 oe low drives", {35'd0, q_drive_o}, 36'd1);

    // R1: processor strobe ignored while en_n high; burst at 19 continues
    start_read(6'd19, 1'b1);
    astb_cpu_n = 1'b0; en_n = 1'b1; addr_i = 6'd3;
    tick(); idle(); tick(); tick();
    chk("R1 ignored strobe data", q_o, mdl[19]);
    chk("R1 ignored strobe drive", {35'd0, q_drive_o}, 36'd1);

    // R1: controller strobe with en3_n high deselects
    idle(); astb_ctl_n = 1'b0; en3_n = 1'b1;
    tick(); idle(); tick(); tick();
    chk("R1 en3 deselect", {35'd0, q_drive_o}, 36'd0);

    // R1: processor strobe with en2 low deselects
    start_read(6'd16, 1'b1);
    astb_cpu_n = 1'b0; en2 = 1'b0;
    tick(); idle(); tick(); tick();
    chk("R1 en2 deselect", {35'd0, q_drive_o}, 36'd0);

    // R9: single-cycle deselect after a read
    start_read(6'd3, 1'b0);
    astb_ctl_n = 1'b0; en2 = 1'b0;
    tick(); idle();
    tick();
    chk("R9 read still driven", {35'd0, q_drive_o}, 36'd1);
    chk("R9 read data", q_o, mdl[3]);
    tick();
    chk("R9 floats next edge", {35'd0, q_drive_o}, 36'd0);
    chk("R9 data held", q_o, mdl[3]);

    // R11: a write continuation inside a burst floats the output
    start_read(6'd63, 1'b1);
    lane_we_n = 4'b1101; d_i = 36'h0_0003_FE00;
    tick(); idle();
    mdl[63][17:9] = 9'h1FF;
    tick(); tick();
    chk("R11 write float", {35'd0, q_drive_o}, 36'd0);
    tick();
    chk("R6 continuation write data", q_o, mdl[63]);
    chk("R8 drive after write", {35'd0, q_drive_o}, 36'd1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule